// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplexer Mode

This block keeps a small bank of single-bit storage cells that are written one at a time from a shared data bit, and the cell to write is chosen by a binary address. Two active-low controls, a clear and an enable, select one of four modes. Write mode stores the data bit into the addressed cell. Hold mode freezes every cell. Decode mode turns the block into a one-hot demultiplexer that routes the data bit to the addressed output. Clear mode forces everything low.

Storage uses ordinary registers. They capture on the rising clock edge while write mode is active. The clear input empties them asynchronously. A block-level reset is synchronised on release and also empties them. To build a wider bank, place several instances that share address and data. Drive each instance's enable from a decode of the higher address bits so that only one instance writes at a time.

Top module: `addr_latch_demux`

## Requirements
- R1: While `rst_n` is low, and after its release with `clr_n` and `en_n` both high, every bit of `q` reads 0.
- R2: The controls select modes as follows, written as {`clr_n`,`en_n`}: 2'b10 is write, 2'b11 is hold, 2'b00 is decode and 2'b01 is clear.
- R3: In write mode, a rising clock edge stores `din` into cell number `addr`. Bit `addr` of `q` shows the new value after that edge.
- R4: In write mode, every cell other than the addressed one keeps its value across the edge.
- R5: In hold mode, no clock edge changes any cell, whatever `addr` and `din` are. `q` equals the stored cells.
- R6: In decode mode, `q` is combinational: bit `addr` equals `din` and every other bit is 0.
- R7: In clear mode, `q` is all zeros for every `addr` and `din`.
- R8: A low level on `clr_n` empties all cells at once, with no clock edge needed. A short low pulse between edges, followed by hold, leaves `q` at zero.
- R9: Decode mode also empties the cells, so a return from decode mode to hold mode shows all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; cells capture on its rising edge |
| rst_n | input | 1 | Block reset, active low, asynchronous assert, synchronised release |
| clr_n | input | 1 | Clear control, active low |
| en_n | input | 1 | Enable control, active low |
| addr | input | ADDR_W | Cell / output select |
| din | input | 1 | Data bit |
| q | output | 2**ADDR_W | Parallel outputs |

## Verification
The bench builds the block with the default `ADDR_W` of 3, which gives eight cells. At that size, every address can be crossed with both data values in each of the four modes. A reference image of the cells is kept in the bench and updated arithmetically after each write. Every output vector is then compared against it, so a stray write into a neighbouring cell is caught as well as a missed write into the target. The asynchronous clear is driven as a pulse that falls entirely between two clock edges. This exercises the path that does not depend on the clock.

// File: rtl/alatch_pkg.sv
package alatch_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE  = 2'd0,
    MODE_HOLD   = 2'd1,
    MODE_DECODE = 2'd2,
    MODE_CLEAR  = 2'd3
  } alatch_mode_e;
endpackage

// File: rtl/alatch_rst_sync.sv
module alatch_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/alatch_mode_dec.sv
module alatch_mode_dec
  import alatch_pkg::*;
(
  input  logic         clr_n,
  input  logic         en_n,
  output alatch_mode_e mode
);
  // R2: {clr_n, en_n} picks one of four modes
  always_comb begin
    case ({clr_n, en_n})
      2'b10:   mode = MODE_WRITE;
      2'b11:   mode = MODE_HOLD;
      2'b00:   mode = MODE_DECODE;
      default: mode = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/alatch_cells.sv
module alatch_cells #(
  parameter int ADDR_W = 3,
  localparam int N_CELLS = 1 << ADDR_W
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               din,
  output logic [N_CELLS-1:0] cells
);
  logic [N_CELLS-1:0] cells_d;
  logic [N_CELLS-1:0] cells_q;
  logic [N_CELLS-1:0] sel;

  for (genvar g = 0; g < N_CELLS; g++) begin : g_sel
    assign sel[g] = wr_en && (addr == ADDR_W'(g));
  end

  always_comb begin
    cells_d = cells_q;
    for (int i = 0; i < N_CELLS; i++) begin
      if (sel[i]) cells_d[i] = din;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)    cells_q <= '0;
    else if (wr_en) cells_q <= cells_d;
  end

  assign cells = cells_q;

  for (genvar g = 0; g < N_CELLS; g++) begin : g_chk
    // R3
    wr_cell_chk: assert property (@(posedge clk) disable iff (!arst_n)
      sel[g] |=> (cells_q[g] == $past(din)));
    // R4
    keep_cell_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !sel[g] |=> ((cells_q[g] == $past(cells_q[g])) || !cells_q[g]));
  end
endmodule

// File: rtl/alatch_outmux.sv
module alatch_outmux
  import alatch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int N_CELLS = 1 << ADDR_W
) (
  input  alatch_mode_e       mode,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               din,
  input  logic [N_CELLS-1:0] cells,
  output logic [N_CELLS-1:0] q
);
  logic [N_CELLS-1:0] onehot;

  for (genvar g = 0; g < N_CELLS; g++) begin : g_dec
    assign onehot[g] = din && (addr == ADDR_W'(g));
  end

  always_comb begin
    case (mode)
      MODE_WRITE, MODE_HOLD: q = cells;
      MODE_DECODE:           q = onehot;
      default:               q = '0;
    endcase
  end
endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux
  import alatch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int N_CELLS = 1 << ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_n,
  input  logic               en_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               din,
  output logic [N_CELLS-1:0] q
);
  alatch_mode_e       mode;
  logic               rst_sync_n;
  logic               arst_n;
  logic               wr_en;
  logic [N_CELLS-1:0] cells;

  alatch_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  alatch_mode_dec u_mode (.clr_n(clr_n), .en_n(en_n), .mode(mode));

  // clear low (clear or decode mode) empties the cells asynchronously
  assign arst_n = rst_sync_n & clr_n;
  assign wr_en  = (mode == MODE_WRITE);

  alatch_cells #(.ADDR_W(ADDR_W)) u_cells (
    .clk(clk), .arst_n(arst_n), .wr_en(wr_en),
    .addr(addr), .din(din), .cells(cells)
  );

  alatch_outmux #(.ADDR_W(ADDR_W)) u_mux (
    .mode(mode), .addr(addr), .din(din), .cells(cells), .q(q)
  );

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (mode == MODE_HOLD) |=> ((cells == $past(cells)) || (cells == '0)));
  // R6
  dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DECODE) |-> ($onehot0(q) && (q[addr] == din)));
  // R7
  clr_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CLEAR) |-> (q == '0));
  // R8
  clr_cells_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (cells == '0));
endmodule

// File: tb/sim_addr_latch_demux.sv
`timescale 1ns/1ps
module sim_addr_latch_demux;
  logic       clk = 1'b0;
  logic       rst_n, clr_n, en_n, din;
  logic [2:0] addr;
  logic [7:0] q;
  logic [7:0] model;
  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  addr_latch_demux #(.ADDR_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .en_n(en_n),
    .addr(addr), .din(din), .q(q)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: q=%h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_cell(input int a, input logic d);
    clr_n = 1'b1; en_n = 1'b0; addr = 3'(a); din = d;
    tick();
    model[a] = d;
  endtask

  task automatic load(input logic [7:0] v);
    for (int a = 0; a < 8; a++) write_cell(a, v[a]);
    clr_n = 1'b1; en_n = 1'b1;
    tick();
  endtask

  initial begin
    #(4 * 150000);
    nerr++;
    $display("FAIL watchdog: run did not complete");
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr_n = 1'b1; en_n = 1'b1; addr = '0; din = 1'b0;
    model = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", q, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", q, 8'h00);

    // R3/R4: write mode {clr_n,en_n}=10, both data values at every address
    for (int i = 0; i < 64; i++) begin
      logic d;
      d = 1'((i >> 3) ^ (i >> 1) ^ i);
      write_cell(i % 8, d);
      check("R3 addressed bit", {7'd0, q[i % 8]}, {7'd0, d});
      check("R4 other cells kept", q, model);
    end

    // R5: hold mode {clr_n,en_n}=11 across all address/data pairs
    load(8'h96);
    for (int a = 0; a < 8; a++) begin
      for (int d = 0; d < 2; d++) begin
        clr_n = 1'b1; en_n = 1'b1; addr = 3'(a); din = 1'(d);
        tick();
        check("R5 hold", q, model);
      end
    end

    // R6: decode mode {clr_n,en_n}=00
    for (int a = 0; a < 8; a++) begin
      for (int d = 0; d < 2; d++) begin
        clr_n = 1'b0; en_n = 1'b0; addr = 3'(a); din = 1'(d);
        #0.5;
        check("R6 decode", q, 8'(d) << a);
        tick();
        check("R6 decode after edge", q, 8'(d) << a);
      end
    end
    // R9: back to hold shows empty cells
    clr_n = 1'b1; en_n = 1'b1; model = '0;
    tick();
    check("R9 hold after decode", q, 8'h00);

    // R7: clear mode {clr_n,en_n}=01
    load(8'hA5);
    check("R2 write then hold", q, 8'hA5);
    for (int a = 0; a < 8; a++) begin
      for (int d = 0; d < 2; d++) begin
        clr_n = 1'b0; en_n = 1'b1; addr = 3'(a); din = 1'(d);
        #0.5;
        check("R7 clear", q, 8'h00);
        tick();
      end
    end
    clr_n = 1'b1; en_n = 1'b1; model = '0;
    tick();
    check("R7 hold after clear", q, 8'h00);

    // R8: clear pulse entirely between edges, in hold
    load(8'h5A);
    check("R8 preload", q, 8'h5A);
    #0.3 clr_n = 1'b0;
    #0.5 clr_n = 1'b1;
    #0.3;
    check("R8 async clear before edge", q, 8'h00);
    model = '0;
    tick();
    check("R8 after next edge", q, 8'h00);

    // R2: enable high blocks writes, write mode resumes afterwards
    clr_n = 1'b1; en_n = 1'b1; addr = 3'd6; din = 1'b1;
    tick();
    check("R2 enable high ignores data", q, 8'h00);
    write_cell(6, 1'b1);
    check("R2 enable low writes", q, 8'h40);

    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule